// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the software-facing half of an SPI master. A simple 32-bit register bus (select, write strobe, byte address, write data, combinational read data) reaches ten word registers. These hold the serial engine's enable, clock setup, transmit and receive word formats, frame setup, a status word, interrupt enable and acknowledge words, FIFO control, and one data port. The block stores eight-entry transmit and receive FIFOs. It raises three sticky interrupt flags and drives a single interrupt line. A separate serial engine sits beside it. That engine takes transmit words through a valid/take pair and delivers received words through a valid strobe. It also reports its busy state.

Writing the data port queues a word for transmission and reading it dequeues a received word, so one address serves both directions. The FIFO control word carries a flush command bit for each FIFO; these bits are never stored and read back as 0. The same word holds a fill-level threshold for each FIFO that decides when that FIFO's completion flag is raised. Addresses must be word aligned. An unaligned or unmapped address reads 0 and writes nothing.

Top module: `spi_regfront`

## Requirements
- R1: After reset every register reads 0, except the status word, which reads 0x20 (transmit FIFO not full). All configuration outputs are 0 and `irq` is low.
- R2: The configuration words are at byte offsets 0x00 (enable, bit 0), 0x04 (clock, writable mask 0x70FF), 0x08 (TX format, mask 0x3FFF), 0x0C (RX format, mask 0xFF), 0x10 (frame, mask 0xC000) and 0x18 (interrupt enable, mask 0x19). Each reads back the written value ANDed with its mask and drives the matching `cfg_*` output.
- R3: A write to offset 0x24 appends the low data bits to the transmit FIFO. The engine sees the words on `eng_tx_word` in write order. The FIFO holds 8 words, and a write while it is full is ignored.
- R4: `eng_tx_valid` is high only while the enable bit is 1 and the transmit FIFO is not empty. While the enable bit is 0, queued words stay in the FIFO.
- R5: Status at offset 0x14 has bit 7 equal to `eng_busy`, bit 5 set when the transmit FIFO is not full, bit 0 set when the receive FIFO is not empty, and all other bits 0.
- R6: A read of offset 0x24 returns and removes the oldest received word. A read while the receive FIFO is empty returns 0 and changes nothing.
- R7: At offset 0x20, writing bit 12 empties the transmit FIFO and writing bit 4 empties the receive FIFO. Both bits read back as 0. Bits 11:8 (TX threshold) and 3:0 (RX threshold) are stored and read back.
- R8: A received word that arrives while the receive FIFO holds 8 words and is not being read in that cycle is dropped. It sets the overrun flag, which is bit 0 of the flag word.
- R9: The TX-complete flag (bit 4) is set when the engine takes a word and the transmit level after that cycle is at or below the TX threshold.
- R10: The RX-complete flag (bit 3) is set when a received word is stored and the receive level after that cycle is at or above the RX threshold.
- R11: The pending flags read at offset 0x1C. Writing 1 to bit 4, 3 or 0 there clears that flag and leaves flags written with 0 untouched. A flag event in the same cycle as its clear leaves the flag set.
- R12: `irq` is high exactly when some pending flag has its enable bit (same bit position) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| eng_enable | output | 1 | Controller enable to the engine |
| cfg_clock | output | 32 | Clock setup word |
| cfg_tx_format | output | 32 | Transmit word format |
| cfg_rx_format | output | 32 | Receive word format |
| cfg_frame | output | 32 | Frame setup word |
| eng_tx_valid | output | 1 | A transmit word is offered |
| eng_tx_word | output | WORD_W (32) | Oldest transmit word |
| eng_tx_take | input | 1 | Engine consumes the offered word |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_word | input | WORD_W (32) | Received word |
| eng_busy | input | 1 | Engine is shifting |
| irq | output | 1 | Interrupt request |

## Verification
In every cycle the assertions follow independent level models of both FIFOs and compare them with the stored fill levels. They also check that the offer to the engine never appears while the model level is zero or the controller is disabled, that every status read matches the model levels and the busy input, that an empty data read returns 0, and that a dropped received word raises the overrun flag. The bench alone shows word ordering, the threshold behaviour of the two completion flags across every threshold from 0 to 8, field masking of each configuration word, the priority of a flag event over its clear, and the interrupt line over all 64 combinations of pending and enable bits.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

    localparam int BUS_W = 32;
    localparam int THR_W = 4;
    localparam int IDX_W = 4;

    // Word index = byte address / 4
    typedef enum logic [IDX_W-1:0] {
        RG_CONTROL  = 4'd0,
        RG_CLOCK    = 4'd1,
        RG_TXFMT    = 4'd2,
        RG_RXFMT    = 4'd3,
        RG_FRAME    = 4'd4,
        RG_STATUS   = 4'd5,
        RG_IRQ_EN   = 4'd6,
        RG_IRQ_ACK  = 4'd7,
        RG_FIFO_CTL = 4'd8,
        RG_DATA     = 4'd9
    } reg_sel_e;

    localparam logic [BUS_W-1:0] MASK_CONTROL = 32'h0000_0001;
    localparam logic [BUS_W-1:0] MASK_CLOCK   = 32'h0000_70FF;
    localparam logic [BUS_W-1:0] MASK_TXFMT   = 32'h0000_3FFF;
    localparam logic [BUS_W-1:0] MASK_RXFMT   = 32'h0000_00FF;
    localparam logic [BUS_W-1:0] MASK_FRAME   = 32'h0000_C000;

    localparam int ST_BUSY      = 7;
    localparam int ST_TX_NFULL  = 5;
    localparam int ST_RX_NEMPTY = 0;

    localparam int FC_TX_FLUSH = 12;
    localparam int FC_RX_FLUSH = 4;
    localparam int FC_TX_THR_LO = 8;
    localparam int FC_RX_THR_LO = 0;

    localparam int FL_TX_DONE = 4;
    localparam int FL_RX_DONE = 3;
    localparam int FL_RX_OVR  = 0;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic rx_ovr;
    } flag_vec_t;

    typedef struct packed {
        logic              enable;
        logic [BUS_W-1:0]  clock;
        logic [BUS_W-1:0]  txfmt;
        logic [BUS_W-1:0]  rxfmt;
        logic [BUS_W-1:0]  frame;
    } cfg_t;

    function automatic logic [BUS_W-1:0] flags_to_word(flag_vec_t f);
        logic [BUS_W-1:0] w;
        w = '0;
        w[FL_TX_DONE] = f.tx_done;
        w[FL_RX_DONE] = f.rx_done;
        w[FL_RX_OVR]  = f.rx_ovr;
        return w;
    endfunction

    function automatic flag_vec_t pick_flags(logic b_tx, logic b_rx, logic b_ovr);
        flag_vec_t f;
        f.tx_done = b_tx;
        f.rx_done = b_rx;
        f.rx_ovr  = b_ovr;
        return f;
    endfunction

endpackage

// File: rtl/spi_regfront_fifo.sv
module spi_regfront_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             push_ok,
    output logic             pop_ok
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count != FULL_LVL) || pop_ok);
    assign dout    = store[rd_ptr];

    function automatic logic [PTR_W-1:0] advance(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush)
            store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= advance(wr_ptr);
            if (pop_ok)  rd_ptr <= advance(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_regfront_flags.sv
module spi_regfront_flags
    import spi_regfront_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_evt,
    input  flag_vec_t clr_req,
    input  flag_vec_t enable,
    output flag_vec_t pending,
    output logic      irq
);
    // An event in the same cycle as its clear wins
    always_ff @(posedge clk) begin
        if (rst)
            pending <= '0;
        else
            pending <= (pending & ~clr_req) | set_evt;
    end

    assign irq = |(pending & enable);
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              eng_enable,
    output logic [BUS_W-1:0]  cfg_clock,
    output logic [BUS_W-1:0]  cfg_tx_format,
    output logic [BUS_W-1:0]  cfg_rx_format,
    output logic [BUS_W-1:0]  cfg_frame,
    output logic              eng_tx_valid,
    output logic [WORD_W-1:0] eng_tx_word,
    input  logic              eng_tx_take,
    input  logic              eng_rx_valid,
    input  logic [WORD_W-1:0] eng_rx_word,
    input  logic              eng_busy,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    // Address decode
    logic     aligned_hit;
    reg_sel_e sel_idx;
    logic     in_map;
    logic     wr_hit, rd_hit;

    assign aligned_hit = ((bus_addr >> 6) == '0) && (bus_addr[1:0] == 2'b00);
    assign sel_idx     = reg_sel_e'(bus_addr[5:2]);
    assign in_map      = (bus_addr[5:2] <= 4'(RG_DATA));
    assign wr_hit      = bus_sel && bus_wr && aligned_hit && in_map;
    assign rd_hit      = bus_sel && !bus_wr && aligned_hit && in_map;

    logic wr_fc, wr_data, rd_data, wr_ack;
    assign wr_fc   = wr_hit && (sel_idx == RG_FIFO_CTL);
    assign wr_data = wr_hit && (sel_idx == RG_DATA);
    assign rd_data = rd_hit && (sel_idx == RG_DATA);
    assign wr_ack  = wr_hit && (sel_idx == RG_IRQ_ACK);

    // Configuration storage
    cfg_t             cfg_q;
    flag_vec_t        irq_en_q;
    logic [THR_W-1:0] tx_thr_q, rx_thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            irq_en_q <= '0;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else if (wr_hit) begin
            case (sel_idx)
                RG_CONTROL:  cfg_q.enable <= bus_wdata[0];
                RG_CLOCK:    cfg_q.clock  <= bus_wdata & MASK_CLOCK;
                RG_TXFMT:    cfg_q.txfmt  <= bus_wdata & MASK_TXFMT;
                RG_RXFMT:    cfg_q.rxfmt  <= bus_wdata & MASK_RXFMT;
                RG_FRAME:    cfg_q.frame  <= bus_wdata & MASK_FRAME;
                RG_IRQ_EN:   irq_en_q <= pick_flags(bus_wdata[FL_TX_DONE],
                                                    bus_wdata[FL_RX_DONE],
                                                    bus_wdata[FL_RX_OVR]);
                RG_FIFO_CTL: begin
                    tx_thr_q <= bus_wdata[FC_TX_THR_LO +: THR_W];
                    rx_thr_q <= bus_wdata[FC_RX_THR_LO +: THR_W];
                end
                default: ;
            endcase
        end
    end

    assign eng_enable    = cfg_q.enable;
    assign cfg_clock     = cfg_q.clock;
    assign cfg_tx_format = cfg_q.txfmt;
    assign cfg_rx_format = cfg_q.rxfmt;
    assign cfg_frame     = cfg_q.frame;

    // FIFOs
    logic             tx_flush, rx_flush;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [WORD_W-1:0] rx_head;

    assign tx_flush = wr_fc && bus_wdata[FC_TX_FLUSH];
    assign rx_flush = wr_fc && bus_wdata[FC_RX_FLUSH];

    spi_regfront_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (tx_flush),
        .push    (wr_data),
        .din     (bus_wdata[WORD_W-1:0]),
        .pop     (eng_tx_take && eng_tx_valid),
        .dout    (eng_tx_word),
        .count   (tx_cnt),
        .push_ok (tx_push_ok),
        .pop_ok  (tx_pop_ok)
    );

    spi_regfront_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (rx_flush),
        .push    (eng_rx_valid),
        .din     (eng_rx_word),
        .pop     (rd_data),
        .dout    (rx_head),
        .count   (rx_cnt),
        .push_ok (rx_push_ok),
        .pop_ok  (rx_pop_ok)
    );

    assign eng_tx_valid = cfg_q.enable && (tx_cnt != '0);

    // Flag events
    logic [CMP_W-1:0] tx_lvl_next, rx_lvl_next;
    assign tx_lvl_next = CMP_W'(tx_cnt) + CMP_W'(tx_push_ok) - CMP_W'(tx_pop_ok);
    assign rx_lvl_next = CMP_W'(rx_cnt) + CMP_W'(rx_push_ok) - CMP_W'(rx_pop_ok);

    flag_vec_t evt, clr, pend;
    always_comb begin
        evt.tx_done = tx_pop_ok && !tx_flush && (tx_lvl_next <= CMP_W'(tx_thr_q));
        evt.rx_done = rx_push_ok && !rx_flush && (rx_lvl_next >= CMP_W'(rx_thr_q));
        evt.rx_ovr  = eng_rx_valid && !rx_push_ok && !rx_flush;
        clr = wr_ack ? pick_flags(bus_wdata[FL_TX_DONE], bus_wdata[FL_RX_DONE],
                                  bus_wdata[FL_RX_OVR])
                     : flag_vec_t'('0);
    end

    spi_regfront_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (evt),
        .clr_req (clr),
        .enable  (irq_en_q),
        .pending (pend),
        .irq     (irq)
    );

    // Read mux
    logic [BUS_W-1:0] status_w, fc_w;
    always_comb begin
        status_w = '0;
        status_w[ST_BUSY]      = eng_busy;
        status_w[ST_TX_NFULL]  = (tx_cnt != FULL_LVL);
        status_w[ST_RX_NEMPTY] = (rx_cnt != '0);
        fc_w = '0;
        fc_w[FC_TX_THR_LO +: THR_W] = tx_thr_q;
        fc_w[FC_RX_THR_LO +: THR_W] = rx_thr_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned_hit && in_map) begin
            case (sel_idx)
                RG_CONTROL:  bus_rdata = BUS_W'(cfg_q.enable);
                RG_CLOCK:    bus_rdata = cfg_q.clock;
                RG_TXFMT:    bus_rdata = cfg_q.txfmt;
                RG_RXFMT:    bus_rdata = cfg_q.rxfmt;
                RG_FRAME:    bus_rdata = cfg_q.frame;
                RG_STATUS:   bus_rdata = status_w;
                RG_IRQ_EN:   bus_rdata = flags_to_word(irq_en_q);
                RG_IRQ_ACK:  bus_rdata = flags_to_word(pend);
                RG_FIFO_CTL: bus_rdata = fc_w;
                RG_DATA:     bus_rdata = (rx_cnt != '0) ? BUS_W'(rx_head) : '0;
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_regfront_checker.sv
module spi_regfront_checker #(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              eng_tx_take,
    input logic              eng_tx_valid,
    input logic              eng_rx_valid,
    input logic              eng_busy,
    input logic [CNT_W-1:0]  tx_level,
    input logic [CNT_W-1:0]  rx_level,
    input logic              ovr_pending
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic wr_any, rd_any;
    assign wr_any = bus_sel && bus_wr;
    assign rd_any = bus_sel && !bus_wr;

    logic fc_wr, data_wr, data_rd, stat_rd, ctl_wr;
    assign fc_wr   = wr_any && (bus_addr == ADDR_W'(32'h20));
    assign data_wr = wr_any && (bus_addr == ADDR_W'(32'h24));
    assign data_rd = rd_any && (bus_addr == ADDR_W'(32'h24));
    assign stat_rd = rd_any && (bus_addr == ADDR_W'(32'h14));
    assign ctl_wr  = wr_any && (bus_addr == ADDR_W'(32'h00));

    logic [CNT_W-1:0] tx_m, rx_m;
    logic             en_m;
    logic             take_m, push_m, pop_m, wr_m;

    assign take_m = eng_tx_take && en_m && (tx_m != '0);
    assign wr_m   = data_wr && ((tx_m != FULL) || take_m);
    assign pop_m  = data_rd && (rx_m != '0);
    assign push_m = eng_rx_valid && ((rx_m != FULL) || pop_m);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_m <= '0;
            rx_m <= '0;
            en_m <= 1'b0;
        end else begin
            if (ctl_wr) en_m <= bus_wdata[0];
            if (fc_wr && bus_wdata[12]) tx_m <= '0;
            else tx_m <= tx_m + CNT_W'(wr_m) - CNT_W'(take_m);
            if (fc_wr && bus_wdata[4]) rx_m <= '0;
            else rx_m <= rx_m + CNT_W'(push_m) - CNT_W'(pop_m);
        end
    end

    assert_tx_level_R3: assert property (@(posedge clk) disable iff (rst)
        tx_level == tx_m);

    assert_rx_level_R6: assert property (@(posedge clk) disable iff (rst)
        rx_level == rx_m);

    assert_offer_gated_R4: assert property (@(posedge clk) disable iff (rst)
        eng_tx_valid |-> (en_m && (tx_m != '0)));

    assert_status_bits_R5: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (bus_rdata[7] == eng_busy && bus_rdata[5] == (tx_m != FULL)
                     && bus_rdata[0] == (rx_m != '0)));

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (data_rd && rx_m == '0) |-> (bus_rdata == 32'h0));

    assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_valid && rx_m == FULL && !pop_m && !(fc_wr && bus_wdata[4]))
        |=> ovr_pending);
endmodule

bind spi_regfront spi_regfront_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .eng_tx_take  (eng_tx_take),
    .eng_tx_valid (eng_tx_valid),
    .eng_rx_valid (eng_rx_valid),
    .eng_busy     (eng_busy),
    .tx_level     (tx_cnt),
    .rx_level     (rx_cnt),
    .ovr_pending  (pend.rx_ovr)
);

// File: tb/spi_regfront_test.sv
module spi_regfront_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_enable, eng_tx_valid, irq;
    logic [31:0] cfg_clock, cfg_tx_format, cfg_rx_format, cfg_frame, eng_tx_word;
    logic        eng_tx_take = 1'b0, eng_rx_valid = 1'b0, eng_busy = 1'b0;
    logic [31:0] eng_rx_word = '0;

    int checks = 0, errors = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regfront uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_enable(eng_enable), .cfg_clock(cfg_clock),
        .cfg_tx_format(cfg_tx_format), .cfg_rx_format(cfg_rx_format),
        .cfg_frame(cfg_frame), .eng_tx_valid(eng_tx_valid),
        .eng_tx_word(eng_tx_word), .eng_tx_take(eng_tx_take),
        .eng_rx_valid(eng_rx_valid), .eng_rx_word(eng_rx_word),
        .eng_busy(eng_busy), .irq(irq)
    );

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            summary_and_end();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic take(output logic [31:0] w, output logic v);
        @(negedge clk);
        eng_tx_take = 1'b1;
        #1 w = eng_tx_word; v = eng_tx_valid;
        @(posedge clk); #1;
        eng_tx_take = 1'b0;
    endtask

    task automatic push(logic [31:0] w);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_word = w;
        @(posedge clk); #1;
        eng_rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] expand(logic [2:0] p);
        return {27'b0, p[2], p[1], 2'b00, p[0]};
    endfunction

    logic [31:0] r, w;
    logic v;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        for (int i = 0; i < 10; i++) begin
            rd(6'(i*4), r);
            chk("R1 reset read", r, (i == 5) ? 32'h20 : 32'h0);
        end
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        chk("R1 cfg clock", cfg_clock, 32'h0);

        // R2: masks and outputs
        for (int pat = 0; pat < 3; pat++) begin
            logic [31:0] d;
            d = (pat == 0) ? 32'hFFFF_FFFF : (pat == 1) ? 32'hA5A5_A5A5 : 32'h5A5A_5A5A;
            wr(6'h04, d); wr(6'h08, d); wr(6'h0C, d); wr(6'h10, d); wr(6'h18, d);
            rd(6'h04, r); chk("R2 clock", r, d & 32'h70FF);
            chk("R2 cfg_clock", cfg_clock, d & 32'h70FF);
            rd(6'h08, r); chk("R2 txfmt", r, d & 32'h3FFF);
            chk("R2 cfg_tx_format", cfg_tx_format, d & 32'h3FFF);
            rd(6'h0C, r); chk("R2 rxfmt", r, d & 32'hFF);
            chk("R2 cfg_rx_format", cfg_rx_format, d & 32'hFF);
            rd(6'h10, r); chk("R2 frame", r, d & 32'hC000);
            chk("R2 cfg_frame", cfg_frame, d & 32'hC000);
            rd(6'h18, r); chk("R2 irq enable", r, d & 32'h19);
        end
        wr(6'h18, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, r); chk("R2 control", r, 32'h1);
        chk("R2 eng_enable", {31'b0, eng_enable}, 32'h1);
        wr(6'h00, 32'h0);

        // R4/R3/R5: fill while disabled, overfill, drain in order
        for (int k = 0; k < DEPTH + 1; k++) wr(6'h24, 32'h100 + k);
        chk("R4 no offer while disabled", {31'b0, eng_tx_valid}, 32'h0);
        rd(6'h14, r); chk("R5 status tx full", r, 32'h0);
        eng_busy = 1'b1;
        rd(6'h14, r); chk("R5 status busy", r, 32'h80);
        eng_busy = 1'b0;
        wr(6'h00, 32'h1);
        for (int k = 0; k < DEPTH; k++) begin
            take(w, v);
            chk("R4 offer valid", {31'b0, v}, 32'h1);
            chk("R3 tx order", w, 32'h100 + k);
        end
        #1 chk("R3 ninth write dropped", {31'b0, eng_tx_valid}, 32'h0);

        // R9: TX complete threshold sweep
        for (int t = 0; t <= DEPTH; t++) begin
            wr(6'h20, 32'h1010 | (t << 8));
            wr(6'h1C, 32'h19);
            for (int k = 0; k < DEPTH; k++) wr(6'h24, t * 16 + k);
            for (int k = 1; k <= DEPTH; k++) begin
                take(w, v);
                chk("R3 tx order sweep", w, t * 16 + k - 1);
                rd(6'h1C, r);
                chk("R9 tx done flag", r & 32'h10, ((DEPTH - k) <= t) ? 32'h10 : 32'h0);
            end
        end

        // R10: RX complete threshold sweep; R6 read order
        for (int t = 0; t <= DEPTH; t++) begin
            wr(6'h20, 32'h1010 | t);
            wr(6'h1C, 32'h19);
            for (int k = 1; k <= DEPTH; k++) begin
                push(32'h200 + t * 16 + k);
                rd(6'h1C, r);
                chk("R10 rx done flag", r & 32'h08, (k >= t) ? 32'h08 : 32'h0);
            end
            for (int k = 1; k <= DEPTH; k++) begin
                rd(6'h24, r); chk("R6 rx order", r, 32'h200 + t * 16 + k);
            end
            rd(6'h1C, r); chk("R8 no overrun", r & 32'h1, 32'h0);
        end

        // R8: overrun drops word; R6 empty read
        wr(6'h20, 32'h1010);
        wr(6'h1C, 32'h19);
        for (int k = 0; k < DEPTH + 1; k++) push(32'h300 + k);
        rd(6'h1C, r); chk("R8 overrun set", r & 32'h1, 32'h1);
        rd(6'h14, r); chk("R5 rx not empty", r & 32'h1, 32'h1);
        for (int k = 0; k < DEPTH; k++) begin
            rd(6'h24, r); chk("R8 kept words", r, 32'h300 + k);
        end
        rd(6'h24, r); chk("R6 empty read zero", r, 32'h0);
        rd(6'h14, r); chk("R6 empty status", r, 32'h20);
        push(32'h777);
        rd(6'h24, r); chk("R6 empty read left state", r, 32'h777);

        // R11: selective clear and event-over-clear
        wr(6'h1C, 32'h19);
        wr(6'h24, 32'h1); take(w, v);
        for (int k = 0; k < DEPTH + 1; k++) push(k);
        rd(6'h1C, r); chk("R11 all set", r, 32'h19);
        wr(6'h1C, 32'h10);
        rd(6'h1C, r); chk("R11 clear tx only", r, 32'h09);
        wr(6'h1C, 32'h0);
        rd(6'h1C, r); chk("R11 zero write no effect", r, 32'h09);
        rd(6'h24, r);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h08;
        eng_rx_valid = 1'b1; eng_rx_word = 32'h55;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; eng_rx_valid = 1'b0;
        rd(6'h1C, r); chk("R11 event wins over clear", r, 32'h09);

        // R7: flush and threshold readback
        wr(6'h00, 32'h0);
        wr(6'h24, 32'hAB);
        wr(6'h20, 32'h0000_1A15);
        rd(6'h20, r); chk("R7 fc readback", r, 32'h0000_0A05);
        rd(6'h14, r); chk("R7 both fifos empty", r, 32'h20);
        wr(6'h00, 32'h1);
        #1 chk("R7 tx flushed no offer", {31'b0, eng_tx_valid}, 32'h0);

        // R12: irq over all pending/enable combinations
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 8; e++) begin
                wr(6'h20, 32'h1010);
                wr(6'h1C, 32'h19);
                wr(6'h24, 32'h1); take(w, v);
                for (int k = 0; k < DEPTH + 1; k++) push(k);
                wr(6'h1C, ~expand(3'(p)) & 32'h19);
                wr(6'h18, expand(3'(e)));
                #1 chk("R12 irq", {31'b0, irq}, ((p & e) != 0) ? 32'h1 : 32'h0);
                rd(6'h1C, r); chk("R11 pending pattern", r, expand(3'(p)));
            end
        end

        summary_and_end();
    end
endmodule